// File: doc/BRIEF.md
# Event Counting Performance Monitor

This block counts hardware events for profiling. It holds a small bank of 32-bit up-counters, default four. Each counter chooses one line from a per-cycle event vector. It adds one on every clock in which that line is high, unless a freeze condition applies. The freeze conditions are an individual stop bit, the current privilege level, the state of a mark input, and a unit-wide stop bit.

Profiling software sets a sample period by preloading a counter with 0x80000000 minus the period. When bit 31 of a counter becomes 1 and that counter is allowed to signal, the unit raises a level interrupt. The unit can also stop every counter at that moment, so the sampled counts stay consistent.

All state sits behind a single-cycle register port indexed by register number. Each register also has a read-only user alias.

Top module: `perf_mon_unit`

## Requirements
- R1: After reset every counter, mode, threshold and global register reads zero, and `irq_o` is low.
- R2: Register numbers: counter k at 0x010+k, mode k at 0x090+k, threshold k at 0x110+k, global at 0x190. Only these bits are stored, and all other bits read zero:
  - mode: bits 31:26 and the event select in bits 22:16;
  - threshold: bits 10:8 and 5:0;
  - global: bits 31:29.
- R3: A counter adds one at each clock edge where the event line selected by its mode bits 22:16 is high and no freeze applies.
- R4: Mode bit 31 stops its counter.
- R5: Mode bit 30 stops the counter while `priv_i` is 1 (supervisor). Mode bit 29 stops it while `priv_i` is 0 (user).
- R6: Mode bit 28 stops the counter while `mark_i` is 1. Mode bit 27 stops it while `mark_i` is 0.
- R7: Global bit 31 stops all counters.
- R8: A counter signals a condition when its mode bit 26 is set and its bit 31 is 1. `irq_o` is high exactly while global bit 30 is set and some counter signals. It drops once software rewrites that counter.
- R9: While global bit 29 is set and some counter signals, no counter advances. Global bit 31 is set at the next edge. A write that clears bit 31 is overridden while the condition remains.
- R10: Aliases at 0x000+k, 0x080+k, 0x100+k and 0x180 read the same values as the main registers. Writes to them change nothing.
- R11: Other register numbers read zero, and writes to them change nothing.
- R12: A write to a counter in the same cycle as a counted event stores the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | NUM_EVT | Event lines, one per cycle |
| priv_i | input | 1 | 1 = supervisor, 0 = user |
| mark_i | input | 1 | Mark state of the running context |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 10 | Register number |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, same cycle |
| irq_o | output | 1 | Overflow interrupt, level |

## Verification
The hardest state to reach is freeze-on-condition. A counter must cross into bit 31 while events keep arriving. Software must then try to clear the global stop bit while the condition still holds.

The stimulus preloads a counter one below the boundary and holds its event line high for several cycles. It then checks three things: the counter stopped exactly at 0x80000000, other counters stopped too, and a clearing write was overridden. Only after the counter is rewritten does a second clearing write take hold, and counting resumes.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 10;
  localparam int SEL_W     = 7;
  localparam int EVT_SPACE = 1 << SEL_W;

  localparam logic [DATA_W-1:0] MODE_MASK = 32'hFC7F_0000;
  localparam logic [DATA_W-1:0] THR_MASK  = 32'h0000_073F;
  localparam logic [DATA_W-1:0] GLB_MASK  = 32'hE000_0000;

  typedef enum logic [1:0] {
    GRP_CNT  = 2'd0,
    GRP_MODE = 2'd1,
    GRP_THR  = 2'd2,
    GRP_GLB  = 2'd3
  } grp_e;

  typedef struct packed {
    logic             stop;
    logic             stop_sup;
    logic             stop_usr;
    logic             stop_mk1;
    logic             stop_mk0;
    logic             cond_en;
    logic [2:0]       rsv_hi;
    logic [SEL_W-1:0] sel;
    logic [15:0]      rsv_lo;
  } mode_t;

  typedef struct packed {
    logic        stop_all;
    logic        irq_en;
    logic        stop_on_cond;
    logic [28:0] rsv;
  } glb_t;
endpackage

// File: rtl/pmu_addr_dec.sv
module pmu_addr_dec
  import pmu_pkg::*;
#(
  parameter int NUM_CTR = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output grp_e              grp_o,
  output logic [3:0]        idx_o,
  output logic [NUM_CTR-1:0] cnt_we_o,
  output logic [NUM_CTR-1:0] mode_we_o,
  output logic [NUM_CTR-1:0] thr_we_o,
  output logic              glb_we_o
);
  logic sup_alias, idx_ok, frame_ok, wr_ok;

  assign grp_o     = grp_e'(addr_i[8:7]);
  assign idx_o     = addr_i[3:0];
  assign sup_alias = addr_i[4];
  assign frame_ok  = !addr_i[9] && (addr_i[6:5] == 2'b00);
  assign idx_ok    = (grp_o == GRP_GLB) ? (idx_o == 4'd0) : (32'(idx_o) < NUM_CTR);
  assign hit_o     = frame_ok && idx_ok;
  assign wr_ok     = we_i && hit_o && sup_alias;

  for (genvar k = 0; k < NUM_CTR; k++) begin : g_we
    assign cnt_we_o[k]  = wr_ok && (grp_o == GRP_CNT)  && (idx_o == 4'(k));
    assign mode_we_o[k] = wr_ok && (grp_o == GRP_MODE) && (idx_o == 4'(k));
    assign thr_we_o[k]  = wr_ok && (grp_o == GRP_THR)  && (idx_o == 4'(k));
  end
  assign glb_we_o = wr_ok && (grp_o == GRP_GLB);

  // R10: alias writes reach no register
  a_r10_alias_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !addr_i[4]) |-> !(|{cnt_we_o, mode_we_o, thr_we_o, glb_we_o}));
  // R11: at most one register written per cycle
  a_r11_one_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cnt_we_o, mode_we_o, thr_we_o, glb_we_o}));
endmodule

// File: rtl/pmu_slice.sv
module pmu_slice
  import pmu_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [EVT_SPACE-1:0] evt_i,
  input  logic                 priv_i,
  input  logic                 mark_i,
  input  logic                 halt_i,
  input  logic                 cnt_we_i,
  input  logic                 mode_we_i,
  input  logic                 thr_we_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    cnt_o,
  output logic [DATA_W-1:0]    mode_o,
  output logic [DATA_W-1:0]    thr_o,
  output logic                 cond_o
);
  mode_t             mode_q;
  logic [DATA_W-1:0] thr_q, cnt_q;
  logic              blocked, count_en;

  assign blocked = mode_q.stop
                 | (priv_i  & mode_q.stop_sup) | (!priv_i & mode_q.stop_usr)
                 | (mark_i  & mode_q.stop_mk1) | (!mark_i & mode_q.stop_mk0);
  assign count_en = evt_i[mode_q.sel] && !blocked && !halt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      thr_q  <= '0;
      cnt_q  <= '0;
    end else begin
      if (mode_we_i) mode_q <= mode_t'(wdata_i & MODE_MASK);
      if (thr_we_i)  thr_q  <= wdata_i & THR_MASK;
      if (cnt_we_i)      cnt_q <= wdata_i;
      else if (count_en) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign mode_o = mode_q;
  assign thr_o  = thr_q;
  assign cond_o = mode_q.cond_en && cnt_q[DATA_W-1];

  // R4: stopped counter holds unless written
  a_r4_stop_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q.stop && !cnt_we_i) |=> (cnt_q == $past(cnt_q)));
  // R3: at most one step per cycle
  a_r3_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_we_i |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));
  // R12: written value wins over an event
  a_r12_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_we_i |=> (cnt_q == $past(wdata_i)));
endmodule

// File: rtl/pmu_glob.sv
module pmu_glob
  import pmu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              any_cond_i,
  output logic [DATA_W-1:0] glb_o,
  output logic              halt_o,
  output logic              irq_o
);
  glb_t glb_q, glb_d;
  logic cond_stop;

  assign cond_stop = glb_q.stop_on_cond && any_cond_i;

  always_comb begin
    glb_d = glb_q;
    if (we_i) glb_d = glb_t'(wdata_i & GLB_MASK);
    if (cond_stop) glb_d.stop_all = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) glb_q <= '0;
    else         glb_q <= glb_d;
  end

  assign glb_o  = glb_q;
  assign halt_o = glb_q.stop_all || cond_stop;
  assign irq_o  = glb_q.irq_en && any_cond_i;

  // R9: pending condition with stop-on-condition forces the stop bit
  a_r9_cond_sets_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (glb_q.stop_on_cond && any_cond_i) |=> glb_q.stop_all);
  // R8: interrupt only with a signalling counter
  a_r8_irq_needs_cond: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> any_cond_i);
endmodule

// File: rtl/perf_mon_unit.sv
module perf_mon_unit
  import pmu_pkg::*;
#(
  parameter int NUM_CTR = 4,
  parameter int NUM_EVT = 128
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               priv_i,
  input  logic               mark_i,
  input  logic               reg_we_i,
  input  logic [9:0]         reg_addr_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        reg_rdata_o,
  output logic               irq_o
);
  logic [EVT_SPACE-1:0] evt_pad;
  logic                 hit, glb_we, halt;
  grp_e                 grp;
  logic [3:0]           idx;
  logic [NUM_CTR-1:0]   cnt_we, mode_we, thr_we, cond;
  logic [DATA_W-1:0]    cnt_v [NUM_CTR];
  logic [DATA_W-1:0]    mode_v[NUM_CTR];
  logic [DATA_W-1:0]    thr_v [NUM_CTR];
  logic [DATA_W-1:0]    glb_v;

  always_comb begin
    evt_pad = '0;
    evt_pad[NUM_EVT-1:0] = evt_i;
  end

  pmu_addr_dec #(.NUM_CTR(NUM_CTR)) u_dec (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .hit_o(hit), .grp_o(grp), .idx_o(idx),
    .cnt_we_o(cnt_we), .mode_we_o(mode_we), .thr_we_o(thr_we), .glb_we_o(glb_we)
  );

  for (genvar k = 0; k < NUM_CTR; k++) begin : g_ctr
    pmu_slice u_slice (
      .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_pad),
      .priv_i(priv_i), .mark_i(mark_i), .halt_i(halt),
      .cnt_we_i(cnt_we[k]), .mode_we_i(mode_we[k]), .thr_we_i(thr_we[k]),
      .wdata_i(reg_wdata_i),
      .cnt_o(cnt_v[k]), .mode_o(mode_v[k]), .thr_o(thr_v[k]), .cond_o(cond[k])
    );
  end

  pmu_glob u_glob (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(glb_we), .wdata_i(reg_wdata_i),
    .any_cond_i(|cond), .glb_o(glb_v), .halt_o(halt), .irq_o(irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (hit) begin
      if (grp == GRP_GLB) reg_rdata_o = glb_v;
      for (int k = 0; k < NUM_CTR; k++) begin
        if (idx == 4'(k)) begin
          unique case (grp)
            GRP_CNT:  reg_rdata_o = cnt_v[k];
            GRP_MODE: reg_rdata_o = mode_v[k];
            GRP_THR:  reg_rdata_o = thr_v[k];
            default:  ;
          endcase
        end
      end
    end
  end

  // R1: interrupt quiet straight after reset
  a_r1_irq_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !irq_o);
  // R9: halted unit does not advance counter 0 without a write
  a_r9_halt_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt && !cnt_we[0]) |=> (cnt_v[0] == $past(cnt_v[0])));
endmodule

// File: tb/perf_mon_unit_test.sv
`timescale 1ns/1ps
module perf_mon_unit_test;
  logic         clk = 0;
  logic         rst_n = 0;
  logic [127:0] evt = '0;
  logic         priv = 0, mark = 0, we = 0;
  logic [9:0]   addr = '0;
  logic [31:0]  wdata = '0, rdata;
  logic         irq;
  int           n_chk = 0, n_fail = 0;
  logic [31:0]  c0 = 0, v;
  bit           done = 0;

  perf_mon_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .priv_i(priv), .mark_i(mark),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk); we = 0; addr = a; #1 d = rdata;
  endtask

  task automatic pulse(input int b, input int n);
    @(negedge clk); evt[b] = 1;
    repeat (n) @(negedge clk);
    evt[b] = 0;
  endtask

  task automatic expect_reg(input string tag, input logic [9:0] a, input logic [31:0] e);
    rd(a, v); check(tag, v, e);
  endtask

  task automatic t_reset;
    expect_reg("R1 cnt0", 10'h010, 0);
    expect_reg("R1 mode3", 10'h093, 0);
    expect_reg("R1 thr1", 10'h111, 0);
    expect_reg("R1 glb", 10'h190, 0);
    check("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_map;
    wr(10'h092, 32'hFFFF_FFFF); expect_reg("R2 mode mask", 10'h092, 32'hFC7F_0000);
    wr(10'h092, 0);
    wr(10'h113, 32'hFFFF_FFFF); expect_reg("R2 thr mask", 10'h113, 32'h0000_073F);
    wr(10'h190, 32'hFFFF_FFFF); expect_reg("R2 glb mask", 10'h190, 32'hE000_0000);
    wr(10'h190, 0);             expect_reg("R2 glb clear", 10'h190, 0);
  endtask

  task automatic t_count;
    wr(10'h090, 32'h0005_0000);
    wr(10'h010, 100); c0 = 100;
    pulse(5, 10); c0 += 10;
    pulse(6, 3);
    expect_reg("R3 selected event only", 10'h010, c0);
  endtask

  task automatic t_stop;
    wr(10'h090, 32'h8005_0000); pulse(5, 5);
    expect_reg("R4 individual stop", 10'h010, c0);
  endtask

  task automatic t_priv;
    wr(10'h090, 32'h4005_0000);
    priv = 1; pulse(5, 4); expect_reg("R5 sup frozen", 10'h010, c0);
    priv = 0; pulse(5, 4); c0 += 4; expect_reg("R5 user counts", 10'h010, c0);
    wr(10'h090, 32'h2005_0000);
    pulse(5, 4); expect_reg("R5 user frozen", 10'h010, c0);
    priv = 1; pulse(5, 4); c0 += 4; expect_reg("R5 sup counts", 10'h010, c0);
    priv = 0;
  endtask

  task automatic t_mark;
    wr(10'h090, 32'h1005_0000);
    mark = 1; pulse(5, 2); expect_reg("R6 mark1 frozen", 10'h010, c0);
    mark = 0; pulse(5, 2); c0 += 2; expect_reg("R6 mark0 counts", 10'h010, c0);
    wr(10'h090, 32'h0805_0000);
    pulse(5, 2); expect_reg("R6 mark0 frozen", 10'h010, c0);
    mark = 1; pulse(5, 2); c0 += 2; expect_reg("R6 mark1 counts", 10'h010, c0);
    mark = 0;
    wr(10'h090, 32'h0005_0000);
  endtask

  task automatic t_stop_all;
    wr(10'h190, 32'h8000_0000); pulse(5, 3);
    expect_reg("R7 stop all", 10'h010, c0);
    wr(10'h190, 0); pulse(5, 1); c0 += 1;
    expect_reg("R7 resumed", 10'h010, c0);
  endtask

  task automatic t_irq;
    wr(10'h091, 32'h0402_0000);
    wr(10'h011, 32'h7FFF_FFFE);
    wr(10'h190, 32'h4000_0000);
    pulse(2, 1); #1 check("R8 below boundary", 32'(irq), 0);
    pulse(2, 1); #1 check("R8 irq at bit31", 32'(irq), 1);
    wr(10'h011, 0); #1 check("R8 irq cleared by rewrite", 32'(irq), 0);
    wr(10'h091, 32'h0002_0000); wr(10'h011, 32'h8000_0000);
    #1 check("R8 no cond enable", 32'(irq), 0);
    wr(10'h011, 0); wr(10'h091, 32'h0402_0000);
  endtask

  task automatic t_cond_stop;
    wr(10'h190, 32'h6000_0000);
    wr(10'h011, 32'h7FFF_FFFF);
    pulse(2, 5);
    expect_reg("R9 counter stopped at boundary", 10'h011, 32'h8000_0000);
    expect_reg("R9 stop bit set", 10'h190, 32'hE000_0000);
    check("R9 irq", 32'(irq), 1);
    pulse(5, 3);
    expect_reg("R9 others stopped", 10'h010, c0);
    wr(10'h190, 32'h6000_0000);
    expect_reg("R9 clear overridden", 10'h190, 32'hE000_0000);
    wr(10'h011, 0);
    wr(10'h190, 32'h6000_0000);
    expect_reg("R9 clear accepted", 10'h190, 32'h6000_0000);
    pulse(5, 3); c0 += 3;
    expect_reg("R9 counting resumes", 10'h010, c0);
    wr(10'h190, 0);
  endtask

  task automatic t_alias;
    expect_reg("R10 cnt alias read", 10'h000, c0);
    expect_reg("R10 mode alias read", 10'h081, 32'h0402_0000);
    wr(10'h000, 32'h1234);  expect_reg("R10 cnt alias write ignored", 10'h010, c0);
    wr(10'h080, 32'h8000_0000); expect_reg("R10 mode alias write ignored", 10'h090, 32'h0005_0000);
    wr(10'h180, 32'h8000_0000); expect_reg("R10 glb alias write ignored", 10'h190, 0);
  endtask

  task automatic t_unmapped;
    expect_reg("R11 unmapped 0x020", 10'h020, 0);
    expect_reg("R11 unmapped 0x014", 10'h014, 0);
    expect_reg("R11 unmapped 0x191", 10'h191, 0);
    wr(10'h014, 32'hDEAD_BEEF); expect_reg("R11 write ignored", 10'h010, c0);
    wr(10'h210, 32'hDEAD_BEEF); expect_reg("R11 high write ignored", 10'h010, c0);
  endtask

  task automatic t_write_wins;
    @(negedge clk); evt[5] = 1; we = 1; addr = 10'h010; wdata = 7;
    @(negedge clk); evt[5] = 0; we = 0;
    c0 = 7;
    expect_reg("R12 write over event", 10'h010, c0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_map();
    t_count();
    t_stop();
    t_priv();
    t_mark();
    t_stop_all();
    t_irq();
    t_cond_stop();
    t_alias();
    t_unmapped();
    t_write_wins();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule